// File: doc/BRIEF.md
# Modulo Timer with Single PWM Channel

This block is a free-running up-counter with a selectable power-of-two prescaler and a programmable wrap limit, driving one output-compare channel that produces a pulse-width-modulated signal. Each period starts when the counter wraps to zero, which drives the output high. The period ends its active part when the counter steps onto the programmed channel value, which drives the output low. Software programs the wrap limit, the channel value and the prescaler through a plain write strobe with a two-bit register selector. It watches two sticky event flags, which it clears by writing ones.

Channel writes have no shadow copy. A new value replaces the compare target on the next clock edge, whatever the counter is doing. If software writes a value that the counter has already passed, and the old value has not yet been reached, no compare happens in that period. The output then stays high through the next wrap and into the following period. The block keeps this behaviour on purpose. It gives the system a timer with a known, bounded glitch window.

Top module: `pwm_modtimer`

## Requirements
- R1: While `rst_n` is low, and right after it rises, the block is in its reset state: counter 0, wrap limit 0xFFFF, channel value 0, prescaler code 0, `pwm_out` low, both flags clear. From that state the counter counts up to 0xFFFF and wraps to 0.
- R2: A write takes effect at the rising clock edge where `wr_en` is high. `wr_sel` picks the target: code 0 is the wrap limit (`wr_data`), code 1 is the channel value (`wr_data`), code 2 is the prescaler code (`wr_data[2:0]`), and code 3 is flag clear.
- R3: The counter advances once every 2^s clock cycles, where s is the prescaler code. Codes 0 to 6 divide by 1, 2, 4, 8, 16, 32 and 64, and code 7 divides by 64. Code 0 advances the counter on every cycle.
- R4: On an advance, the counter goes to 0 if its value is greater than or equal to the wrap limit, and otherwise goes up by one. The period is therefore (limit + 1) advances.
- R5: The overflow flag (`ovf_flag`) is set on the edge where the counter wraps. It stays set until a flag-clear write with `wr_data[0]` = 1. A new wrap in the same cycle as that clear wins over the clear.
- R6: `pwm_out` goes high on the edge where the counter wraps. It goes low on the edge where the counter takes the channel value, so it is high for (channel value) advances of each period. If both happen on the same edge, the compare wins, so a channel value of 0 keeps the output low.
- R7: The compare flag (`cmp_flag`) is set on the edge where the counter takes the channel value. It stays set until a flag-clear write with `wr_data[1]` = 1, and a new compare in the same cycle wins over the clear.
- R8: A channel value greater than the wrap limit never matches, so `pwm_out` stays high (100 percent duty).
- R9: A channel write replaces the compare target at once. If the new value is below the current count, the compare of that period is skipped, and `pwm_out` stays high until the compare of the following period. The total high time is then (limit + 1) + (new value) advances, which is less than two periods.
- R10: A wrap-limit write takes effect at once. If the counter is already above the new limit, it wraps on its next advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 limit, 1 channel, 2 prescaler, 3 flag clear |
| wr_data | input | 16 | Write data |
| count | output | 16 | Current counter value |
| pwm_out | output | 1 | PWM output, high during the active part of the period |
| ovf_flag | output | 1 | Sticky wrap event flag |
| cmp_flag | output | 1 | Sticky compare event flag |

## Verification
A wrong prescaler phase or counter value shows as a `count` that steps at the wrong spacing, or as a period that differs from (limit + 1)·2^s. Either shows within one period, and a direct step check shows it within a single advance. A wrong compare target or a misordered wrap/compare priority shows on `pwm_out` as a high run that does not equal channel·2^s, at the first rising edge of the output. A flag that fails to set or fails to clear shows on the cycle after the wrap, compare or clear-write edge.

// File: rtl/pwm_modtimer_pkg.sv
package pwm_modtimer_pkg;

  // Register selector codes on the write port
  typedef enum logic [1:0] {
    SEL_LIMIT    = 2'd0,
    SEL_CHANNEL  = 2'd1,
    SEL_PRESCALE = 2'd2,
    SEL_CLEAR    = 2'd3
  } wr_target_e;

  // Bit positions inside a flag-clear write
  localparam int CLR_OVF_BIT = 0;
  localparam int CLR_CMP_BIT = 1;

endpackage

// File: rtl/pwm_mt_prescaler.sv
// Power-of-two tick generator: one tick every 2^code cycles.
module pwm_mt_prescaler #(
  parameter int SEL_W     = 3,
  parameter int MAX_SHIFT = 6,
  localparam int PRE_W    = MAX_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  logic [PRE_W-1:0] pre_q;

  // Low-bit mask whose all-ones state marks a tick; codes above MAX_SHIFT saturate
  function automatic logic [PRE_W-1:0] div_mask(input logic [SEL_W-1:0] s);
    logic [PRE_W:0] full;
    int sh;
    sh   = (int'(s) > MAX_SHIFT) ? MAX_SHIFT : int'(s);
    full = ({{PRE_W{1'b0}}, 1'b1} << sh) - 1'b1;
    return full[PRE_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end

  assign tick = ((pre_q & div_mask(sel)) == div_mask(sel));

endmodule

// File: rtl/pwm_mt_counter.sv
// Modulo up-counter; wraps when the value has reached or passed the limit.
module pwm_mt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] step_val,
  output logic             wrap_evt
);

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c,
                                                  input logic [CNT_W-1:0] lim);
    return (c >= lim) ? '0 : c + 1'b1;
  endfunction

  assign step_val = next_count(cnt_q, limit);
  assign wrap_evt = tick && (cnt_q >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= step_val;
  end

endmodule

// File: rtl/pwm_mt_channel.sv
// Output-compare channel: high on wrap, low when the counter steps onto the target.
module pwm_mt_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wrap_evt,
  input  logic [CNT_W-1:0] step_val,
  input  logic [CNT_W-1:0] target,
  output logic             cmp_evt,
  output logic             pwm_q
);

  function automatic logic hits(input logic t, input logic [CNT_W-1:0] nxt,
                                input logic [CNT_W-1:0] tgt);
    return t && (nxt == tgt);
  endfunction

  assign cmp_evt = hits(tick, step_val, target);

  // Compare has priority so a zero target yields a constant low output
  always_ff @(posedge clk) begin
    if (!rst_n)        pwm_q <= 1'b0;
    else if (cmp_evt)  pwm_q <= 1'b0;
    else if (wrap_evt) pwm_q <= 1'b1;
  end

endmodule

// File: rtl/pwm_mt_regs.sv
// Software-written registers and sticky event flags.
module pwm_mt_regs
  import pwm_modtimer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             wrap_evt,
  input  logic             cmp_evt,
  output logic [CNT_W-1:0] limit_q,
  output logic [CNT_W-1:0] target_q,
  output logic [SEL_W-1:0] psel_q,
  output logic             ovf_q,
  output logic             cmp_q
);

  logic clr_ovf, clr_cmp;

  assign clr_ovf = wr_en && (wr_target_e'(wr_sel) == SEL_CLEAR) && wr_data[CLR_OVF_BIT];
  assign clr_cmp = wr_en && (wr_target_e'(wr_sel) == SEL_CLEAR) && wr_data[CLR_CMP_BIT];

  // A fresh event in the same cycle wins over the clear
  function automatic logic sticky(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      limit_q  <= '1;
      target_q <= '0;
      psel_q   <= '0;
    end else if (wr_en) begin
      case (wr_target_e'(wr_sel))
        SEL_LIMIT:    limit_q  <= wr_data;
        SEL_CHANNEL:  target_q <= wr_data;
        SEL_PRESCALE: psel_q   <= wr_data[SEL_W-1:0];
        default:      ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      cmp_q <= 1'b0;
    end else begin
      ovf_q <= sticky(ovf_q, wrap_evt, clr_ovf);
      cmp_q <= sticky(cmp_q, cmp_evt, clr_cmp);
    end
  end

endmodule

// File: rtl/pwm_modtimer.sv
// Modulo timer with one unbuffered PWM output-compare channel.
module pwm_modtimer #(
  parameter int CNT_W     = 16,
  parameter int SEL_W     = 3,
  parameter int MAX_SHIFT = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] count,
  output logic             pwm_out,
  output logic             ovf_flag,
  output logic             cmp_flag
);

  // Named internal events, also observed by the bound checker
  logic             tick;
  logic             wrap_evt;
  logic             cmp_evt;
  logic [CNT_W-1:0] step_val;
  logic [CNT_W-1:0] limit_q;
  logic [CNT_W-1:0] target_q;
  logic [SEL_W-1:0] psel_q;

  pwm_mt_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .wrap_evt (wrap_evt),
    .cmp_evt  (cmp_evt),
    .limit_q  (limit_q),
    .target_q (target_q),
    .psel_q   (psel_q),
    .ovf_q    (ovf_flag),
    .cmp_q    (cmp_flag)
  );

  pwm_mt_prescaler #(.SEL_W(SEL_W), .MAX_SHIFT(MAX_SHIFT)) u_psc (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (psel_q),
    .tick  (tick)
  );

  pwm_mt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .limit    (limit_q),
    .cnt_q    (count),
    .step_val (step_val),
    .wrap_evt (wrap_evt)
  );

  pwm_mt_channel #(.CNT_W(CNT_W)) u_ch (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .wrap_evt (wrap_evt),
    .step_val (step_val),
    .target   (target_q),
    .cmp_evt  (cmp_evt),
    .pwm_q    (pwm_out)
  );

endmodule

// File: rtl/pwm_modtimer_chk.sv
module pwm_modtimer_chk #(
  parameter int CNT_W = 16,
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             wrap_evt,
  input logic             cmp_evt,
  input logic [SEL_W-1:0] psel_q,
  input logic [CNT_W-1:0] count,
  input logic             pwm_out,
  input logic             ovf_flag,
  input logic             cmp_flag
);

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (count == '0 && !pwm_out && !ovf_flag && !cmp_flag));

  assert_code0_every_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (psel_q == '0) |-> tick);

  assert_hold_between_ticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));

  assert_step_by_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wrap_evt) |=> (count == $past(count) + 1'b1));

  assert_wrap_to_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (count == '0));

  assert_ovf_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> ovf_flag);

  assert_cmp_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_evt |=> (cmp_flag && !pwm_out));

  assert_wrap_drives_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && !cmp_evt) |=> pwm_out);

  assert_rise_only_at_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_out) |-> $past(wrap_evt));

endmodule

bind pwm_modtimer pwm_modtimer_chk #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .wrap_evt (wrap_evt),
  .cmp_evt  (cmp_evt),
  .psel_q   (psel_q),
  .count    (count),
  .pwm_out  (pwm_out),
  .ovf_flag (ovf_flag),
  .cmp_flag (cmp_flag)
);

// File: tb/pwm_modtimer_test.sv
`timescale 1ns/1ps
module pwm_modtimer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic [15:0] count;
  logic        pwm_out, ovf_flag, cmp_flag;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  pwm_modtimer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .count(count), .pwm_out(pwm_out), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Called at a falling edge; the write lands on the next rising edge
  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_rise();
    logic prev;
    prev = pwm_out;
    @(negedge clk);
    while (!(pwm_out && !prev)) begin
      prev = pwm_out;
      @(negedge clk);
    end
  endtask

  // Measures one high run and the following low run, starting at a rise
  task automatic measure(output int hi, output int lo);
    wait_rise();
    hi = 0; lo = 0;
    while (pwm_out) begin hi++; @(negedge clk); end
    while (!pwm_out) begin lo++; @(negedge clk); end
  endtask

  task automatic setup(input int lim, input int ch, input int ps);
    wr(2'd2, 16'(ps));
    wr(2'd0, 16'(lim));
    wr(2'd1, 16'(ch));
  endtask

  task automatic test_reset();
    int c0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "count in reset", int'(count), 0);
    check("R1", "pwm in reset", int'(pwm_out), 0);
    check("R1", "flags in reset", int'({ovf_flag, cmp_flag}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    c0 = int'(count);
    @(negedge clk);
    check("R3", "code 0 advances every cycle", int'(count), c0 + 1);
    while (count != 16'hFFFF) @(negedge clk);
    check("R1", "no wrap before 0xFFFF", int'(ovf_flag), 0);
    @(negedge clk);
    check("R1", "wrap after 0xFFFF count", int'(count), 0);
    check("R5", "ovf set on wrap", int'(ovf_flag), 1);
    check("R6", "channel 0 keeps output low", int'(pwm_out), 0);
  endtask

  task automatic test_duty(input string req, input int lim, input int ch, input int ps, input int div);
    int hi, lo;
    setup(lim, ch, ps);
    measure(hi, lo);
    measure(hi, lo);
    check(req, "high run", hi, ch * div);
    check(req, "period", hi + lo, (lim + 1) * div);
  endtask

  task automatic test_flags();
    setup(9, 4, 0);
    wait_rise();          // counter is 0 here
    check("R5", "ovf set at period start", int'(ovf_flag), 1);
    wr(2'd3, 16'h0001);   // counter 1
    check("R5", "ovf cleared by bit 0", int'(ovf_flag), 0);
    check("R7", "cmp untouched by bit 0 clear", int'(cmp_flag), 1);
    wr(2'd3, 16'h0002);   // counter 2
    check("R7", "cmp cleared by bit 1", int'(cmp_flag), 0);
    repeat (2) @(negedge clk); // counter 4
    check("R7", "cmp set when counter takes channel value", int'(cmp_flag), 1);
    check("R6", "output low after compare", int'(pwm_out), 0);
    check("R5", "ovf stays clear mid period", int'(ovf_flag), 0);
    repeat (6) @(negedge clk); // counter 0
    check("R4", "wrap after limit", int'(count), 0);
    check("R5", "ovf set again on wrap", int'(ovf_flag), 1);
  endtask

  task automatic test_full_duty();
    int lows = 0;
    setup(20, 30, 0);
    repeat (50) @(negedge clk);
    for (int i = 0; i < 100; i++) begin
      if (!pwm_out) lows++;
      @(negedge clk);
    end
    check("R8", "low samples with channel above limit", lows, 0);
  endtask

  task automatic test_hazard();
    int rest;
    setup(99, 80, 0);
    wait_rise();              // counter 0
    repeat (50) @(negedge clk); // counter 50
    check("R9", "high before late write", int'(pwm_out), 1);
    wr(2'd1, 16'd30);         // counter 51, already past 30
    rest = 0;
    while (pwm_out) begin rest++; @(negedge clk); end
    check("R9", "high run after missed compare", 51 + rest, 100 + 30);
    check("R2", "channel register accepted new value", int'(count), 30);
  endtask

  task automatic test_limit_write();
    setup(255, 300, 0);
    while (count < 16'd200) @(negedge clk);
    wr(2'd3, 16'h0001);
    wr(2'd0, 16'd50);         // counter now above 50
    @(negedge clk);
    check("R10", "wrap at next advance after lower limit", int'(count), 0);
    check("R10", "ovf on forced wrap", int'(ovf_flag), 1);
    repeat (50) @(negedge clk);
    check("R10", "counter reaches new limit", int'(count), 50);
    @(negedge clk);
    check("R4", "wrap at new limit", int'(count), 0);
  endtask

  initial begin
    test_reset();
    test_duty("R6", 255, 128, 0, 1);
    test_duty("R3", 9, 3, 2, 4);
    test_duty("R3", 3, 1, 7, 64);
    test_duty("R6", 7, 7, 1, 2);
    test_flags();
    test_full_duty();
    test_hazard();
    test_limit_write();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule